// File: doc/BRIEF.md
# Serial Hex Keypad Scanner

The block reads a sixteen-key hex keypad that sits behind a chain of two parallel-in, serial-out shift registers. Each key line has a pull-up, so a pressed key reads as 0. When a scan is requested, the block drives an active-low load line to latch all sixteen key lines at once. It then releases the line so that the chain shifts, and it toggles a shift clock sixteen times while it samples the serial data line.

The assembled 16-bit word is searched from its top bit downward, and the first zero found wins. The position of that zero is translated through a fixed, non-sequential table into the 4-bit value printed on the key. The result appears as a one-cycle strobe with the key value. When no key is down, a separate one-cycle strobe appears instead. Debounce and auto-repeat belong to whatever consumes these strobes.

Top module: `keypad_scan_top`

## Requirements
- R1: After reset, loadN is high, shiftClk is low, keyValid and noKey are low and keyCode is 0.
- R2: A scanStart seen while idle drives loadN low from the next clock for exactly LOAD_CYC cycles. shiftClk stays low while loadN is low.
- R3: Each scan produces exactly 16 rising edges of shiftClk. The first rise comes HALF_CYC cycles after loadN returns high, and shiftClk is low while the block is idle.
- R4: serIn is sampled on each rising shiftClk edge, most significant bit first. The first eight bits form bits 15..8 of the word and the next eight form bits 7..0.
- R5: A 0 bit means a pressed key. The search runs from bit 15 downward, and the highest-numbered zero bit decides the result. Its position index is 15 minus the bit number, so bit 15 is index 0.
- R6: Position index 0 through 15 gives keyCode 3,2,1,0,8,9,A,B,7,6,5,4,C,D,E,F in that order. keyCode changes only in a cycle where keyValid is high.
- R7: If all sixteen bits are 1, noKey pulses, keyValid stays low and keyCode keeps its previous value. keyValid and noKey are never high together.
- R8: The result strobe (keyValid or noKey) and keyCode are updated together one cycle after the edge that captures the sixteenth bit. The strobe lasts one cycle.
- R9: A scanStart that arrives while a scan is in progress is ignored. It neither restarts the load pulse nor queues a second scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanStart | input | 1 | Request one scan (accepted only while idle) |
| serIn | input | 1 | Serial data from the end of the shift-register chain |
| loadN | output | 1 | Low: chain latches key lines; high: chain shifts |
| shiftClk | output | 1 | Shift clock to the chain |
| keyValid | output | 1 | One-cycle strobe: a key was found |
| noKey | output | 1 | One-cycle strobe: no key was pressed |
| keyCode | output | 4 | Value of the winning key |

## Verification
A stuck or miscounted bit counter shows up at the ports within one scan. shiftClk then gives 15 or 17 rises, or the strobe lands a cycle early or late against the sixteenth rise. A wrong shift direction or byte order, or a search that runs the wrong way, shows on keyCode as soon as a pattern holds zeros in both bytes. Sweeping every single-key position exposes any error in the remap table. A control state that leaks out of idle shows as a second load pulse after a mid-scan request, within a few cycles of the strobe.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
  localparam int WORD_W = 16;
  localparam int KEY_W  = 4;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // sample serIn at this edge (shiftClk rises)
    logic finish;   // word complete: search and publish
  } scanCtl_t;

  // scan position (0 = top bit) to printed key value
  function automatic logic [KEY_W-1:0] posToKey(input logic [IDX_W-1:0] pos);
    logic [KEY_W-1:0] k;
    case (pos)
      4'd0:  k = 4'h3;
      4'd1:  k = 4'h2;
      4'd2:  k = 4'h1;
      4'd3:  k = 4'h0;
      4'd4:  k = 4'h8;
      4'd5:  k = 4'h9;
      4'd6:  k = 4'hA;
      4'd7:  k = 4'hB;
      4'd8:  k = 4'h7;
      4'd9:  k = 4'h6;
      4'd10: k = 4'h5;
      4'd11: k = 4'h4;
      4'd12: k = 4'hC;
      4'd13: k = 4'hD;
      4'd14: k = 4'hE;
      default: k = 4'hF;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/keypad_scan_ctrl.sv
module keypad_scan_ctrl
  import keypad_scan_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int LOAD_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     scanStart,
  output logic     loadN,
  output logic     shiftClk,
  output scanCtl_t ctl
);
  localparam int PH_W = $clog2(2 * HALF_CYC) + 1;
  localparam int LD_W = $clog2(LOAD_CYC) + 1;
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_CYC - 1);
  localparam logic [LD_W-1:0]  LD_LAST  = LD_W'(LOAD_CYC - 1);
  localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(WORD_W - 1);

  scanState_t       state;
  logic [PH_W-1:0]  phaseCnt;
  logic [LD_W-1:0]  loadCnt;
  logic [IDX_W-1:0] bitCnt;
  logic             loadNQ;
  logic             sclkQ;

  always_comb begin
    ctl.capture = (state == ST_SHIFT) && (phaseCnt == PH_RISE);
    ctl.finish  = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      loadNQ   <= 1'b1;
      sclkQ    <= 1'b0;
      phaseCnt <= '0;
      loadCnt  <= '0;
      bitCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (scanStart) begin
            state   <= ST_LOAD;
            loadNQ  <= 1'b0;
            loadCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (loadCnt == LD_LAST) begin
            state    <= ST_SHIFT;
            loadNQ   <= 1'b1;
            phaseCnt <= '0;
            bitCnt   <= '0;
          end else begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ctl.capture) begin
            sclkQ    <= 1'b1;
            bitCnt   <= bitCnt + 1'b1;
            phaseCnt <= phaseCnt + 1'b1;
            if (bitCnt == BIT_LAST) state <= ST_DONE;
          end else if (phaseCnt == PH_LAST) begin
            sclkQ    <= 1'b0;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          sclkQ <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign loadN    = loadNQ;
  assign shiftClk = sclkQ;
endmodule

// File: rtl/keypad_scan_dp.sv
module keypad_scan_dp
  import keypad_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  scanCtl_t         ctl,
  output logic             keyValid,
  output logic             noKey,
  output logic [KEY_W-1:0] keyCode
);
  logic [WORD_W-1:0] shiftReg;
  logic              found;
  logic [IDX_W-1:0]  hitPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '1;
    else if (ctl.capture) shiftReg <= {shiftReg[WORD_W-2:0], serIn};
  end

  // later (higher) bits override earlier ones: top zero wins
  always_comb begin
    found  = 1'b0;
    hitPos = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (!shiftReg[i]) begin
        found  = 1'b1;
        hitPos = IDX_W'(WORD_W - 1 - i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyValid <= 1'b0;
      noKey    <= 1'b0;
      keyCode  <= '0;
    end else begin
      keyValid <= ctl.finish && found;
      noKey    <= ctl.finish && !found;
      if (ctl.finish && found) keyCode <= posToKey(hitPos);
    end
  end
endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top
  import keypad_scan_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int LOAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scanStart,
  input  logic       serIn,
  output logic       loadN,
  output logic       shiftClk,
  output logic       keyValid,
  output logic       noKey,
  output logic [3:0] keyCode
);
  scanCtl_t ctl;

  keypad_scan_ctrl #(.HALF_CYC(HALF_CYC), .LOAD_CYC(LOAD_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scanStart (scanStart),
    .loadN     (loadN),
    .shiftClk  (shiftClk),
    .ctl       (ctl)
  );

  keypad_scan_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .ctl      (ctl),
    .keyValid (keyValid),
    .noKey    (noKey),
    .keyCode  (keyCode)
  );
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk (
  input logic       clk,
  input logic       rstN,
  input logic       loadN,
  input logic       shiftClk,
  input logic       keyValid,
  input logic       noKey,
  input logic [3:0] keyCode
);
  logic       prevLd;
  logic       prevSc;
  logic       busy;
  logic [4:0] riseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLd  <= 1'b1;
      prevSc  <= 1'b0;
      busy    <= 1'b0;
      riseCnt <= '0;
    end else begin
      prevLd <= loadN;
      prevSc <= shiftClk;
      if (prevLd && !loadN) begin
        busy    <= 1'b1;
        riseCnt <= '0;
      end else begin
        if (keyValid || noKey) busy <= 1'b0;
        if (shiftClk && !prevSc) riseCnt <= riseCnt + 1'b1;
      end
    end
  end

  assert_no_clk_in_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |-> !shiftClk);

  assert_sixteen_rises_R3: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid || noKey) |-> (riseCnt == 5'd16));

  assert_code_only_with_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(keyCode) |-> keyValid);

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({keyValid, noKey}));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid || noKey) |=> !(keyValid || noKey));

  assert_after_last_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid || noKey) |-> ($past(shiftClk) && !shiftClk));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && riseCnt != 5'd0) |-> loadN);
endmodule

bind keypad_scan_top keypad_scan_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .loadN    (loadN),
  .shiftClk (shiftClk),
  .keyValid (keyValid),
  .noKey    (noKey),
  .keyCode  (keyCode)
);

// File: tb/tb_keypad_scan_top.sv
module tb_keypad_scan_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_CYC   = 4;
  localparam int LOAD_CYC   = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scanStart = 1'b0;
  logic       serIn;
  logic       loadN, shiftClk, keyValid, noKey;
  logic [3:0] keyCode;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;
  logic [3:0] lastCode = 4'h0;
  logic [15:0] keyState = 16'hFFFF;
  logic [15:0] chain = 16'hFFFF;
  logic        benchPrevSc = 1'b0;
  int expKey [16] = '{3, 2, 1, 0, 8, 9, 10, 11, 7, 6, 5, 4, 12, 13, 14, 15};

  always #(CLK_PERIOD / 2) clk = ~clk;

  keypad_scan_top #(.HALF_CYC(HALF_CYC), .LOAD_CYC(LOAD_CYC)) dut (
    .clk(clk), .rstN(rstN), .scanStart(scanStart), .serIn(serIn),
    .loadN(loadN), .shiftClk(shiftClk), .keyValid(keyValid),
    .noKey(noKey), .keyCode(keyCode)
  );

  // model of two cascaded parallel-in serial-out registers, ones shifted in
  always @(posedge clk) begin
    benchPrevSc <= shiftClk;
    if (!loadN) chain <= keyState;
    else if (shiftClk && !benchPrevSc) chain <= {chain[14:0], 1'b1};
  end
  assign serIn = chain[15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkReset();
    @(negedge clk);
    check(loadN === 1'b1, "R1 loadN", int'(loadN), 1);
    check(shiftClk === 1'b0, "R1 shiftClk", int'(shiftClk), 0);
    check(keyValid === 1'b0 && noKey === 1'b0, "R1 strobes", int'({keyValid, noKey}), 0);
    check(keyCode === 4'h0, "R1 keyCode", int'(keyCode), 0);
  endtask

  // one full scan; midStart pulses scanStart during shifting
  task automatic runScan(input logic [15:0] keys, input bit expFound,
                         input int expCode, input bit midStart, input string tag);
    int rises = 0, loadLow = 0, loadFalls = 0, lowLen = 0, early = 0;
    logic pSc = 1'b0, pLd = 1'b1;
    keyState = keys;
    @(negedge clk) scanStart = 1'b1;
    @(negedge clk) scanStart = 1'b0;
    for (int cyc = 0; cyc < 2000 && rises < 16; cyc++) begin
      if (!loadN) loadLow++;
      if (pLd && !loadN) loadFalls++;
      if (shiftClk && !pSc) rises++;
      if (!loadN && shiftClk) early++;
      if (loadN && loadLow > 0 && rises == 0 && !shiftClk) lowLen++;
      if (keyValid || noKey) early++;
      pSc = shiftClk;
      pLd = loadN;
      if (rises < 16) begin
        @(negedge clk);
        scanStart = (midStart && rises == 5) ? 1'b1 : 1'b0;
      end
    end
    scanStart = 1'b0;
    check(loadLow == LOAD_CYC, {"R2 load width ", tag}, loadLow, LOAD_CYC);
    check(loadFalls == 1, {"R9 load pulses ", tag}, loadFalls, 1);
    check(lowLen == HALF_CYC, {"R3 first low phase ", tag}, lowLen, HALF_CYC);
    check(rises == 16 && early == 0, {"R3 rises/no early strobe ", tag}, rises * 100 + early, 1600);
    @(negedge clk);
    check(keyValid === expFound && noKey === !expFound,
          {"R8 strobe timing ", tag}, int'({keyValid, noKey}), int'({expFound, !expFound}));
    if (expFound) begin
      check(keyCode === 4'(expCode), {"R6 keyCode ", tag}, int'(keyCode), expCode);
      lastCode = 4'(expCode);
    end else begin
      check(keyCode === lastCode, {"R7 keyCode held ", tag}, int'(keyCode), int'(lastCode));
    end
    @(negedge clk);
    check(!keyValid && !noKey, {"R8 single pulse ", tag}, int'({keyValid, noKey}), 0);
    check(shiftClk === 1'b0, {"R3 idle clock low ", tag}, int'(shiftClk), 0);
    if (midStart) begin
      for (int k = 0; k < 6; k++) begin
        check(loadN === 1'b1, {"R9 no queued scan ", tag}, int'(loadN), 1);
        @(negedge clk);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic testEveryPosition();
    for (int p = 0; p < 16; p++) begin
      logic [15:0] k = ~(16'h8000 >> p);
      runScan(k, 1'b1, expKey[p], 1'b0, $sformatf("R6 single pos %0d", p));
    end
  endtask

  task automatic testPriority();
    runScan(16'hF6FE, 1'b1, 8, 1'b0, "R5 bit11 over bit8 and bit0");
    runScan(16'h0000, 1'b1, 3, 1'b0, "R5 all pressed");
    runScan(16'hFEFF, 1'b1, 11, 1'b0, "R4 upper byte low bit");
    runScan(16'hFFFD, 1'b1, 14, 1'b0, "R4 lower byte bit1");
    runScan(16'hFF7E, 1'b1, 7, 1'b0, "R5 bit7 over bit0");
  endtask

  task automatic testNoKey();
    runScan(16'hFFFF, 1'b0, 0, 1'b0, "R7 no key");
  endtask

  task automatic testStartDuringScan();
    runScan(16'hDFFF, 1'b1, 1, 1'b1, "R9 start mid-scan");
    runScan(16'hFFFF, 1'b0, 0, 1'b1, "R9 start mid-scan no key");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkReset();
    testEveryPosition();
    testPriority();
    testNoKey();
    testStartDuringScan();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule